// File: doc/BRIEF.md
# Load/Store Unit with Low-Byte Merge

This block is the memory stage of a 32-bit processor pipeline. For each request from the execute stage it adds a sign-extended 16-bit offset to a base register value to form a byte address. It then drives a synchronous word-wide memory port with per-byte write enables. Four operations are supported: whole-word load, whole-word store, single-byte load and single-byte store. Bytes are little-endian within a word, so address bits 1:0 select the lane. The word index sent to memory is the byte address with those two bits dropped.

A byte load does not zero- or sign-extend. Only bits 7:0 of the destination register change, and bits 31:8 keep the value the execute stage passes in with the request. Word accesses whose address is not a multiple of four do not touch memory and raise a misalignment flag instead. Load results come back on a writeback port one cycle after the request, which matches the read latency of the memory. A new request may be issued on every cycle.

Top module: `lsu_unit`

## Requirements
- R1: The byte address equals `req_base` plus `req_offset` sign-extended to 32 bits. `mem_addr` carries bits 31:2 of that sum.
- R2: A word load (`req_op` = 0) with address bits 1:0 equal to zero asserts `mem_en` with `mem_we` low and all four `mem_be` bits set. In the next cycle it asserts `wb_en` with `wb_data` equal to `mem_rdata` and `wb_rd` equal to the request's `req_rd`.
- R3: A byte load (`req_op` = 1) asserts `mem_en` with exactly one `mem_be` bit set, namely bit `addr[1:0]`. In the next cycle, `wb_data[7:0]` holds byte lane `addr[1:0]` of `mem_rdata` (lane n = bits 8n+7:8n), and `wb_data[31:8]` equals `req_dest_old[31:8]` from the request.
- R4: A word store (`req_op` = 2) with address bits 1:0 equal to zero asserts `mem_en` and `mem_we` with all four `mem_be` bits set and `mem_wdata` equal to `req_sdata`. It never produces a writeback.
- R5: A byte store (`req_op` = 3) asserts `mem_en` and `mem_we` with only `mem_be` bit `addr[1:0]` set. The enabled lane of `mem_wdata` carries `req_sdata[7:0]`, the other bytes of the memory word are left unchanged, and no writeback occurs.
- R6: A word load or store whose address bits 1:0 are nonzero keeps `mem_en` low. In the next cycle it asserts `misaligned` and keeps `wb_en` low, and memory contents stay unchanged.
- R7: While `rst` is high and in the first cycle after it, `wb_en` and `misaligned` are low.
- R8: When `req_valid` is low, `mem_en` is low and no writeback or `misaligned` follows in the next cycle.
- R9: Requests on back-to-back cycles are each accepted, and each load's writeback appears in order one cycle after its own request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 word load, 1 byte load, 2 word store, 3 byte store |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed address offset |
| req_sdata | input | 32 | Store source register value |
| req_dest_old | input | 32 | Current value of the load destination register |
| req_rd | input | 5 | Destination register index |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_be | output | 4 | Per-byte write enables, bit n = lane n |
| mem_addr | output | 30 | Word index |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read |
| wb_en | output | 1 | Register writeback enable |
| wb_rd | output | 5 | Writeback register index |
| wb_data | output | 32 | Writeback value |
| misaligned | output | 1 | Previous request was a misaligned word access |

## Verification
The assertions assume `req_valid` is held low during reset and that `mem_rdata` is a registered read of the word addressed in the previous cycle. The bench guarantees both: it releases reset with the request idle and models memory as a clocked array that updates its read register only when `mem_en` is high. It drives every request on the falling edge, so operation codes and offsets are stable around each rising edge.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    LSU_LDW = 2'd0,
    LSU_LDB = 2'd1,
    LSU_STW = 2'd2,
    LSU_STB = 2'd3
  } lsu_op_e;

  function automatic logic op_is_byte(input logic [1:0] op);
    return op[0];
  endfunction

  function automatic logic op_is_store(input logic [1:0] op);
    return op[1];
  endfunction
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 16,
  parameter int LANE_BITS = 2
) (
  input  logic [DATA_W-1:0]           base,
  input  logic [OFS_W-1:0]            offset,
  input  logic                        word_op,
  output logic [DATA_W-LANE_BITS-1:0] word_idx,
  output logic [LANE_BITS-1:0]        lane,
  output logic                        misalign
);
  localparam int EXT_W = DATA_W - OFS_W;

  logic [DATA_W-1:0] ofs_ext;
  logic [DATA_W-1:0] byte_addr;

  assign ofs_ext   = {{EXT_W{offset[OFS_W-1]}}, offset};
  assign byte_addr = base + ofs_ext;
  assign word_idx  = byte_addr[DATA_W-1:LANE_BITS];
  assign lane      = byte_addr[LANE_BITS-1:0];
  assign misalign  = word_op && (lane != '0);
endmodule

// File: rtl/lsu_lanes.sv
module lsu_lanes #(
  parameter int DATA_W = 32,
  parameter int LANE_BITS = 2
) (
  input  logic                   byte_op,
  input  logic [LANE_BITS-1:0]   lane,
  input  logic [DATA_W-1:0]      sdata,
  output logic [DATA_W/8-1:0]    be,
  output logic [DATA_W-1:0]      wdata
);
  localparam int LANES = DATA_W / 8;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be[g] = byte_op ? (lane == LANE_BITS'(g)) : 1'b1;
    assign wdata[g*8 +: 8] = byte_op ? sdata[7:0] : sdata[g*8 +: 8];
  end
endmodule

// File: rtl/lsu_merge.sv
module lsu_merge #(
  parameter int DATA_W = 32,
  parameter int LANE_BITS = 2
) (
  input  logic                 byte_op,
  input  logic [LANE_BITS-1:0] lane,
  input  logic [DATA_W-9:0]    keep_hi,
  input  logic [DATA_W-1:0]    rdata,
  output logic [DATA_W-1:0]    result
);
  logic [7:0] picked;

  assign picked = rdata[{lane, 3'b000} +: 8];
  assign result = byte_op ? {keep_hi, picked} : rdata;
endmodule

// File: rtl/lsu_unit.sv
module lsu_unit #(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 16,
  parameter int RIDX_W = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic [1:0]                  req_op,
  input  logic [DATA_W-1:0]           req_base,
  input  logic [OFS_W-1:0]            req_offset,
  input  logic [DATA_W-1:0]           req_sdata,
  input  logic [DATA_W-1:0]           req_dest_old,
  input  logic [RIDX_W-1:0]           req_rd,
  output logic                        mem_en,
  output logic                        mem_we,
  output logic [DATA_W/8-1:0]         mem_be,
  output logic [DATA_W-$clog2(DATA_W/8)-1:0] mem_addr,
  output logic [DATA_W-1:0]           mem_wdata,
  input  logic [DATA_W-1:0]           mem_rdata,
  output logic                        wb_en,
  output logic [RIDX_W-1:0]           wb_rd,
  output logic [DATA_W-1:0]           wb_data,
  output logic                        misaligned
);
  import lsu_pkg::*;

  localparam int LANES     = DATA_W / 8;
  localparam int LANE_BITS = $clog2(LANES);

  logic                 byte_op;
  logic                 store_op;
  logic [LANE_BITS-1:0] lane;
  logic                 misal;
  logic                 fire;

  assign byte_op  = op_is_byte(req_op);
  assign store_op = op_is_store(req_op);

  lsu_agen #(.DATA_W(DATA_W), .OFS_W(OFS_W), .LANE_BITS(LANE_BITS)) u_agen (
    .base     (req_base),
    .offset   (req_offset),
    .word_op  (!byte_op),
    .word_idx (mem_addr),
    .lane     (lane),
    .misalign (misal)
  );

  lsu_lanes #(.DATA_W(DATA_W), .LANE_BITS(LANE_BITS)) u_lanes (
    .byte_op (byte_op),
    .lane    (lane),
    .sdata   (req_sdata),
    .be      (mem_be),
    .wdata   (mem_wdata)
  );

  assign fire   = req_valid && !misal;
  assign mem_en = fire;
  assign mem_we = store_op;

  // Load context held for the cycle in which read data returns
  logic                 ld_q;
  logic                 byte_q;
  logic [LANE_BITS-1:0] lane_q;
  logic [DATA_W-9:0]    hi_q;
  logic [RIDX_W-1:0]    rd_q;
  logic                 mis_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_q   <= 1'b0;
      byte_q <= 1'b0;
      lane_q <= '0;
      hi_q   <= '0;
      rd_q   <= '0;
      mis_q  <= 1'b0;
    end else begin
      ld_q   <= fire && !store_op;
      byte_q <= byte_op;
      lane_q <= lane;
      hi_q   <= req_dest_old[DATA_W-1:8];
      rd_q   <= req_rd;
      mis_q  <= req_valid && misal;
    end
  end

  lsu_merge #(.DATA_W(DATA_W), .LANE_BITS(LANE_BITS)) u_merge (
    .byte_op (byte_q),
    .lane    (lane_q),
    .keep_hi (hi_q),
    .rdata   (mem_rdata),
    .result  (wb_data)
  );

  assign wb_en      = ld_q;
  assign wb_rd      = rd_q;
  assign misaligned = mis_q;

  AST_BYTE_SINGLE_LANE: assert property (@(posedge clk) disable iff (rst)
    (mem_en && req_op[0]) |-> ($countones(mem_be) == 1)); // R3
  AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !req_op[0]) |-> (&mem_be)); // R2
  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we) |=> !wb_en); // R4
  AST_MISALIGN_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    misaligned |-> (!wb_en && $past(req_valid && !mem_en))); // R6
  AST_WB_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> $past(mem_en && !mem_we)); // R2
  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> !mem_en); // R8
endmodule

// File: tb/lsu_unit_test.sv
module lsu_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [31:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [31:0] req_sdata = '0;
  logic [31:0] req_dest_old = '0;
  logic [4:0]  req_rd = '0;
  logic        mem_en, mem_we;
  logic [3:0]  mem_be;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        wb_en;
  logic [4:0]  wb_rd;
  logic [31:0] wb_data;
  logic        misaligned;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_unit uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_base(req_base), .req_offset(req_offset), .req_sdata(req_sdata),
    .req_dest_old(req_dest_old), .req_rd(req_rd),
    .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .wb_en(wb_en), .wb_rd(wb_rd), .wb_data(wb_data), .misaligned(misaligned)
  );

  logic [31:0] ram [256];

  always_ff @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) ram[mem_addr[7:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      end else begin
        mem_rdata <= ram[mem_addr[7:0]];
      end
    end
  end

  // Values captured by issue(): port state of this request, writeback of the previous one
  logic        p_en, p_we;
  logic [3:0]  p_be;
  logic [29:0] p_addr;
  logic [31:0] p_wdata;
  logic        w_en, w_mis;
  logic [4:0]  w_rd;
  logic [31:0] w_data;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [1:0] op, input logic [31:0] base,
                       input logic [15:0] ofs, input logic [31:0] sd,
                       input logic [31:0] old, input logic [4:0] rd);
    @(negedge clk);
    w_en = wb_en; w_mis = misaligned; w_rd = wb_rd; w_data = wb_data;
    req_valid = v; req_op = op; req_base = base; req_offset = ofs;
    req_sdata = sd; req_dest_old = old; req_rd = rd;
    #1;
    p_en = mem_en; p_we = mem_we; p_be = mem_be; p_addr = mem_addr; p_wdata = mem_wdata;
  endtask

  task automatic idle();
    issue(1'b0, 2'd0, '0, '0, '0, '0, '0);
  endtask

  task automatic t_reset();
    chk("R7 wb_en in reset", {31'd0, wb_en}, 32'd0);
    chk("R7 misaligned in reset", {31'd0, misaligned}, 32'd0);
    @(negedge clk); rst = 1'b0;
    idle();
    chk("R7 wb_en after reset", {31'd0, w_en}, 32'd0);
    chk("R7 misaligned after reset", {31'd0, w_mis}, 32'd0);
  endtask

  task automatic t_word_store_load();
    issue(1'b1, 2'd2, 32'h30, 16'h0010, 32'h12345678, '0, 5'd1);
    chk("R4 mem_en", {31'd0, p_en}, 32'd1);
    chk("R4 mem_we", {31'd0, p_we}, 32'd1);
    chk("R4 mem_be", {28'd0, p_be}, 32'hF);
    chk("R1 word index", {2'd0, p_addr}, 32'h10);
    chk("R4 wdata", p_wdata, 32'h12345678);
    idle();
    chk("R4 no writeback after store", {31'd0, w_en}, 32'd0);
    issue(1'b1, 2'd0, 32'h40, 16'h0000, '0, 32'hFFFFFFFF, 5'd7);
    chk("R2 read enable", {31'd0, p_en & ~p_we}, 32'd1);
    chk("R2 read be", {28'd0, p_be}, 32'hF);
    idle();
    chk("R2 wb_en", {31'd0, w_en}, 32'd1);
    chk("R2 wb_rd", {27'd0, w_rd}, 32'd7);
    chk("R2 wb_data", w_data, 32'h12345678);
  endtask

  task automatic t_negative_offset();
    ram[8'h40] = 32'h0BADCAFE;
    issue(1'b1, 2'd0, 32'h108, 16'hFFF8, '0, '0, 5'd2);
    chk("R1 negative offset index", {2'd0, p_addr}, 32'h40);
    idle();
    chk("R1 negative offset data", w_data, 32'h0BADCAFE);
  endtask

  task automatic t_byte_load();
    ram[8'h20] = 32'h44332211;
    for (int k = 0; k < 4; k++) begin
      issue(1'b1, 2'd1, 32'h7C, 16'(4 + k), '0, 32'hCAFEF00D, 5'(k + 10));
      chk("R3 byte load be", {28'd0, p_be}, 32'(1 << k));
      chk("R3 byte load index", {2'd0, p_addr}, 32'h20);
      idle();
      chk("R3 byte load wb_en", {31'd0, w_en}, 32'd1);
      chk("R3 byte merge", w_data, {24'hCAFEF0, 8'(8'h11 * (k + 1))});
    end
  endtask

  task automatic t_byte_store();
    issue(1'b1, 2'd3, 32'h40, 16'h0002, 32'hFFFFFFA5, '0, 5'd3);
    chk("R5 byte store be", {28'd0, p_be}, 32'h4);
    chk("R5 byte store we", {31'd0, p_we & p_en}, 32'd1);
    chk("R5 byte store lane data", {24'd0, p_wdata[23:16]}, 32'hA5);
    idle();
    chk("R5 no writeback", {31'd0, w_en}, 32'd0);
    issue(1'b1, 2'd0, 32'h40, 16'h0000, '0, '0, 5'd3);
    idle();
    chk("R5 other bytes kept", w_data, 32'h12A55678);
  endtask

  task automatic t_misaligned();
    issue(1'b1, 2'd0, 32'h40, 16'h0001, '0, '0, 5'd5);
    chk("R6 load no access", {31'd0, p_en}, 32'd0);
    idle();
    chk("R6 flag after load", {31'd0, w_mis}, 32'd1);
    chk("R6 no writeback", {31'd0, w_en}, 32'd0);
    issue(1'b1, 2'd2, 32'h40, 16'h0002, 32'hFFFFFFFF, '0, 5'd5);
    chk("R6 store no access", {31'd0, p_en}, 32'd0);
    idle();
    chk("R6 flag after store", {31'd0, w_mis}, 32'd1);
    issue(1'b1, 2'd0, 32'h40, 16'h0000, '0, '0, 5'd5);
    chk("R6 flag clears", {31'd0, w_mis}, 32'd0);
    idle();
    chk("R6 memory unchanged", w_data, 32'h12A55678);
  endtask

  task automatic t_idle();
    issue(1'b0, 2'd0, 32'h40, 16'h0000, '0, '0, 5'd9);
    chk("R8 idle mem_en", {31'd0, p_en}, 32'd0);
    idle();
    chk("R8 idle no wb", {31'd0, w_en}, 32'd0);
    chk("R8 idle no flag", {31'd0, w_mis}, 32'd0);
  endtask

  task automatic t_back_to_back();
    issue(1'b1, 2'd0, 32'h80, 16'h0000, '0, '0, 5'd3);
    issue(1'b1, 2'd1, 32'h40, 16'h0003, '0, 32'h55667700, 5'd4);
    chk("R9 first wb_en", {31'd0, w_en}, 32'd1);
    chk("R9 first rd", {27'd0, w_rd}, 32'd3);
    chk("R9 first data", w_data, 32'h44332211);
    idle();
    chk("R9 second rd", {27'd0, w_rd}, 32'd4);
    chk("R9 second data", w_data, 32'h55667712);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = '0;
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_word_store_load();
    t_negative_offset();
    t_byte_load();
    t_byte_store();
    t_misaligned();
    t_idle();
    t_back_to_back();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule